// File: doc/BRIEF.md
# Dual-Width Condition Code Unit

This block adds or subtracts two 64-bit integer operands and derives two independent condition-code sets from the single result. One set describes the operation as a 32-bit operation on the low words. The other set describes the full 64-bit operation. When the write enable is high, both sets are captured together on the clock edge.

The same block answers branch and test queries. A query picks one of the two stored sets and a 4-bit condition code. The result is a single true/taken bit, produced combinationally from the stored flags. Downstream logic can therefore decide a sign, zero or overflow branch in either width without a separate compare for each width.

Top module: `dualcc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both flag sets are cleared to 0. Each set is packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R2: When `wr_en` is high at a clock edge, both sets load the flags of the current operation in that edge. When `wr_en` is low, both sets keep their values.
- R3: N and Z of the 64-bit set come from the full result. N and Z of the 32-bit set come from result bits 31..0 only, where N is bit 31.
- R4: C is the carry out of the top bit of the width: bit 63 for the 64-bit set and bit 31 for the 32-bit set. For a subtraction (`op_sub`=1), C is 1 when no borrow occurs, which is when the unsigned operand `a` is at least `b` in that width.
- R5: V is signed two's-complement overflow of the operation, judged separately for each width.
- R6: `q_set`=0 selects the 32-bit set and `q_set`=1 selects the 64-bit set. The codes 0 to 5 make `q_true` equal to Z, !Z, N, !N, V and !V of the selected set, in that order.
- R7: Code 6 makes `q_true` always 1. Codes 7 to 15 make `q_true` always 0.
- R8: A query in the same cycle as a write sees the flags stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| op_sub | input | 1 | 1 = a - b, 0 = a + b |
| wr_en | input | 1 | Capture both flag sets at the next edge |
| q_set | input | 1 | Query set select: 0 = 32-bit, 1 = 64-bit |
| q_cond | input | 4 | Query condition code |
| flags32 | output | 4 | Stored 32-bit flags {N,Z,V,C} |
| flags64 | output | 4 | Stored 64-bit flags {N,Z,V,C} |
| q_true | output | 1 | Query result |

## Verification
A wrong carry split or overflow term appears on `flags32` or `flags64` one edge after the operation that exposes it. Such an operation is a carry that crosses bit 31 but not bit 63, or a sign overflow in only one width. A wrong set select or code decode shows on `q_true` in the same cycle as the query. A lost write or a spurious write is found through queries issued during a later hold cycle, which must still reflect the last written flags.

// File: rtl/dualcc_pkg.sv
package dualcc_pkg;

    parameter int unsigned DATA_W = 64;
    parameter int unsigned LO_W   = 32;
    parameter int unsigned CODE_W = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccflags_t;

    typedef enum logic [CODE_W-1:0] {
        CC_ZERO    = 4'd0,
        CC_NONZERO = 4'd1,
        CC_NEG     = 4'd2,
        CC_POS     = 4'd3,
        CC_OVF     = 4'd4,
        CC_NOOVF   = 4'd5,
        CC_ALWAYS  = 4'd6
    } cccode_t;

    // Predicate over one flag set; unlisted codes evaluate false.
    function automatic logic cc_test(input ccflags_t f, input logic [CODE_W-1:0] code);
        logic r;
        case (code)
            CC_ZERO:    r = f.z;
            CC_NONZERO: r = !f.z;
            CC_NEG:     r = f.n;
            CC_POS:     r = !f.n;
            CC_OVF:     r = f.v;
            CC_NOOVF:   r = !f.v;
            CC_ALWAYS:  r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    // Signed overflow from operand and result sign bits (b already inverted for subtract).
    function automatic logic sgn_ovf(input logic sa, input logic sb, input logic sr);
        return (sa == sb) && (sr != sa);
    endfunction

endpackage

// File: rtl/dualcc_adder.sv
module dualcc_adder
    import dualcc_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned LW = LO_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output ccflags_t     f_lo,
    output ccflags_t     f_hi
);
    localparam int unsigned HW = W - LW;

    logic [W-1:0]  bx;
    logic [LW:0]   sum_lo;
    logic [HW:0]   sum_hi;
    logic [W-1:0]  res;

    always_comb begin
        bx     = sub ? ~b : b;
        sum_lo = {1'b0, a[LW-1:0]} + {1'b0, bx[LW-1:0]} + {{LW{1'b0}}, sub};
        sum_hi = {1'b0, a[W-1:LW]} + {1'b0, bx[W-1:LW]} + {{HW{1'b0}}, sum_lo[LW]};
        res    = {sum_hi[HW-1:0], sum_lo[LW-1:0]};

        f_lo.n = res[LW-1];
        f_lo.z = (res[LW-1:0] == '0);
        f_lo.v = sgn_ovf(a[LW-1], bx[LW-1], res[LW-1]);
        f_lo.c = sum_lo[LW];

        f_hi.n = res[W-1];
        f_hi.z = (res == '0);
        f_hi.v = sgn_ovf(a[W-1], bx[W-1], res[W-1]);
        f_hi.c = sum_hi[HW];
    end
endmodule

// File: rtl/dualcc_ccreg.sv
module dualcc_ccreg
    import dualcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  ccflags_t d,
    output ccflags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/dualcc_query.sv
module dualcc_query
    import dualcc_pkg::*;
#(
    parameter int unsigned NSETS = 2
) (
    input  ccflags_t                   sets [NSETS],
    input  logic [$clog2(NSETS)-1:0]   sel,
    input  logic [CODE_W-1:0]          code,
    output logic                       hit
);
    ccflags_t picked;

    always_comb begin
        picked = sets[sel];
        hit    = cc_test(picked, code);
    end
endmodule

// File: rtl/dualcc_unit.sv
module dualcc_unit
    import dualcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                op_sub,
    input  logic                wr_en,
    input  logic                q_set,
    input  logic [CODE_W-1:0]   q_cond,
    output logic [3:0]          flags32,
    output logic [3:0]          flags64,
    output logic                q_true
);
    localparam int unsigned NSETS = 2;

    ccflags_t nxt  [NSETS];
    ccflags_t held [NSETS];

    dualcc_adder #(.W(DATA_W), .LW(LO_W)) u_add (
        .a    (a),
        .b    (b),
        .sub  (op_sub),
        .f_lo (nxt[0]),
        .f_hi (nxt[1])
    );

    for (genvar gi = 0; gi < NSETS; gi++) begin : g_set
        dualcc_ccreg u_reg (
            .clk (clk),
            .rst (rst),
            .we  (wr_en),
            .d   (nxt[gi]),
            .q   (held[gi])
        );
    end

    dualcc_query #(.NSETS(NSETS)) u_q (
        .sets (held),
        .sel  (q_set),
        .code (q_cond),
        .hit  (q_true)
    );

    assign flags32 = held[0];
    assign flags64 = held[1];
endmodule

// File: rtl/dualcc_unit_chk.sv
module dualcc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [63:0] a,
    input logic [63:0] b,
    input logic        op_sub,
    input logic        wr_en,
    input logic        q_set,
    input logic [3:0]  q_cond,
    input logic [3:0]  flags32,
    input logic [3:0]  flags64,
    input logic        q_true
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (flags32 == 4'd0 && flags64 == 4'd0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(flags32) && $stable(flags64))); // R2

    AST_ZERO_SUB64: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_sub) |=> (flags64[2] == ($past(a) == $past(b)))); // R3

    AST_ZERO_SUB32: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_sub) |=> (flags32[2] == ($past(a[31:0]) == $past(b[31:0])))); // R3

    AST_NOBORROW64: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_sub) |=> (flags64[0] == ($past(a) >= $past(b)))); // R4

    AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (rst)
        (q_cond == 4'd6) |-> q_true); // R7

    AST_UNUSED_FALSE: assert property (@(posedge clk) disable iff (rst)
        (q_cond > 4'd6) |-> !q_true); // R7
endmodule

bind dualcc_unit dualcc_unit_chk u_chk (.*);

// File: tb/dualcc_unit_bench.sv
module dualcc_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] a, b;
    logic        op_sub, wr_en, q_set;
    logic [3:0]  q_cond;
    logic [3:0]  flags32, flags64;
    logic        q_true;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m32, m64;

    always #10 clk = ~clk;

    dualcc_unit u_dualcc_unit (
        .clk(clk), .rst(rst), .a(a), .b(b), .op_sub(op_sub), .wr_en(wr_en),
        .q_set(q_set), .q_cond(q_cond), .flags32(flags32), .flags64(flags64),
        .q_true(q_true)
    );

    // Expected flags {N,Z,V,C}; wide selects 64-bit view.
    function automatic logic [3:0] model(input logic [63:0] x, input logic [63:0] y,
                                         input logic s, input logic wide);
        logic [64:0] full;
        logic [32:0] low;
        logic [63:0] r;
        logic n, z, v, c;
        if (s) begin
            r = x - y;
            c = wide ? (x >= y) : (x[31:0] >= y[31:0]);
        end else begin
            full = {1'b0, x} + {1'b0, y};
            low  = {1'b0, x[31:0]} + {1'b0, y[31:0]};
            r    = full[63:0];
            c    = wide ? full[64] : low[32];
        end
        if (wide) begin
            n = r[63]; z = (r == 64'd0);
            v = s ? ((x[63] != y[63]) && (r[63] != x[63])) : ((x[63] == y[63]) && (r[63] != x[63]));
        end else begin
            n = r[31]; z = (r[31:0] == 32'd0);
            v = s ? ((x[31] != y[31]) && (r[31] != x[31])) : ((x[31] == y[31]) && (r[31] != x[31]));
        end
        return {n, z, v, c};
    endfunction

    function automatic logic pred(input logic [3:0] f, input logic [3:0] code);
        case (code)
            4'd0: return f[2];
            4'd1: return !f[2];
            4'd2: return f[3];
            4'd3: return !f[3];
            4'd4: return f[1];
            4'd5: return !f[1];
            4'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive after negedge, check query before edge, flags after edge.
    task automatic step(input logic [63:0] x, input logic [63:0] y, input logic s,
                        input logic we, input logic sel, input logic [3:0] code,
                        input string req);
        @(negedge clk);
        a = x; b = y; op_sub = s; wr_en = we; q_set = sel; q_cond = code;
        #1;
        chk({3'b0, q_true}, {3'b0, pred(sel ? m64 : m32, code)}, {req, " query R6 R8"});
        @(posedge clk);
        #1;
        if (we) begin
            m32 = model(x, y, s, 1'b0);
            m64 = model(x, y, s, 1'b1);
        end
        chk(flags32, m32, {req, " flags32 R2"});
        chk(flags64, m64, {req, " flags64 R2"});
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; a = '0; b = '0; op_sub = 0; wr_en = 1; q_set = 0; q_cond = 0;
        m32 = 4'd0; m64 = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        chk(flags32, 4'd0, "R1 reset flags32");
        chk(flags64, 4'd0, "R1 reset flags64");
        @(negedge clk);
        rst = 1'b0; wr_en = 0;

        // R3 R4: carry out of bit 31 only; 32-bit zero, 64-bit nonzero
        step(64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 0, 4'd0, "R3 R4 carry32");
        chk(flags32, 4'b0101, "R3 R4 low wrap");
        chk(flags64, 4'b0000, "R3 R4 wide no wrap");
        // R5: 32-bit signed overflow only
        step(64'h0000_0000_7FFF_FFFF, 64'd1, 0, 1, 1, 4'd0, "R5 ovf32");
        chk(flags32, 4'b1010, "R5 ovf32 set");
        chk(flags64, 4'b0000, "R5 ovf64 clear");
        // R5: 64-bit signed overflow
        step(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 0, 4'd4, "R5 ovf64");
        chk(flags64, 4'b1010, "R5 ovf64 set");
        // R8: query during write sees old flags (64 V=1), then new
        step(64'd5, 64'd5, 1, 1, 1, 4'd4, "R8 same cycle");
        chk(flags64, 4'b0101, "R4 equal sub no borrow");
        chk(flags32, 4'b0101, "R4 equal sub 32");
        // R4: borrow
        step(64'd0, 64'd1, 1, 1, 0, 4'd2, "R4 borrow");
        chk(flags32, 4'b1000, "R4 borrow 32");
        chk(flags64, 4'b1000, "R4 borrow 64");
        // R2: hold with different operands; query all codes both sets
        for (int sel = 0; sel < 2; sel++)
            for (int code = 0; code < 16; code++)
                step(64'h1234, 64'h1234, 1, 0, sel[0], code[3:0], "R2 R6 R7 hold sweep");
        chk(flags64, 4'b1000, "R2 held after idle");

        for (int i = 0; i < 400; i++) begin
            logic [63:0] x, y;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (i % 5 == 0) y = x;
            if (i % 7 == 0) y[63:32] = x[63:32];
            step(x, y, $urandom % 2, ($urandom % 4) != 0, $urandom % 2, 4'($urandom % 16),
                 "R3 R4 R5 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule